// File: doc/BRIEF.md
# Indirect Rule Table Access Bridge

This block sits on a narrow host register bus and gives software byte-by-byte access to a set of per-port rule tables. Each port owns a table of 16 entries, and each entry holds a 14-byte rule word. The host never addresses a table directly. It fills a per-port staging area one byte at a time and then writes an entry-control byte. That write moves the whole staged word into one table entry, under a byte-enable mask, or loads one entry back into staging. A completion flag in the entry-control byte tells software when the move has finished.

Three host registers carry every access:

- **Select register (address 0).** Picks the table class, the direction and the port.
- **Offset register (address 1).** Names a byte inside the selected port's staging area. Writing it starts the access.
- **Data register (address 2).** In write direction, a write to it stores one byte into staging. In read direction, writing the offset captures the addressed staging byte, and a read of the data register returns it. Software polls the completion flag by rewriting the offset of the entry-control byte and reading the data register.

Top module: `acl_indirect_bridge`

## Requirements
- R1: A host read strobe produces `host_rvalid` high in exactly the next cycle and never otherwise. Address 0 returns the select register, address 1 the offset register, address 2 the captured data byte and address 3 returns 0x00.
- R2: The select byte is decoded as follows. Bits[7:5] equal to 3'b010 choose the rule table. Bits[3:0] give the port, 1 to 5. Bit 4 set is read direction and bit 4 clear is write direction.
- R3: In write direction with a valid selection, a data-register write stores the byte at the current offset of the selected port's staging area.
- R4: In read direction with a valid selection, an offset write captures the staging byte at the new offset for a later data-register read. Data-register writes in read direction change nothing.
- R5: Staging offsets 0x00 to 0x0D hold rule-word bytes 0 to 13. Offset 0x11 holds mask bits 7:0. Offset 0x10 holds mask bits 13:8 in its bits 5:0, and its bits 7:6 read as zero.
- R6: Offset 0x12 is the entry-control byte. Bits[3:0] pick the entry. Writing it with bit 4 set commits staging into that entry. Writing it with bit 4 clear loads all 14 bytes of that entry into staging and leaves the other entries unchanged.
- R7: A commit updates only the entry bytes whose mask bit is 1, where mask bit i belongs to byte i. Bytes with a 0 mask bit keep their old value.
- R8: Bit 5 of the entry-control byte is the done flag. Any write of the entry-control byte clears it. The move happens, and the flag sets, exactly XFER_LAT clock edges after the write edge.
- R9: Offset 0x13 keeps a read/write mode bit in bit 0, and its bits 7:1 read as zero. Every other offset at or above 0x0E ignores writes and reads 0x00.
- R10: A select byte with a table class other than 3'b010, or a port outside 1 to 5, makes data writes do nothing, and an offset write then captures 0x00.
- R11: Each port has its own staging area and its own table. An access to one port never changes another port.
- R12: After reset, the host registers, the captured byte, `host_rvalid`, all staging bytes, the mask, the mode bit, the done flag and all table entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Host register address: 0 select, 1 offset, 2 data |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Read byte, valid while `host_rvalid` is high |
| host_rvalid | output | 1 | High one cycle after a read strobe |

## Verification
Some properties are checked on every cycle by assertions:

- the one-cycle read-valid timing;
- the cleared done flag after a control write, and that it stays low while a move is pending;
- the zero capture on an invalid selection;
- the zero padding of the narrow mask and mode bytes;
- that at most one port receives a write strobe.

Other behaviour is shown only by the bench's scenarios: what the table contents are after masked commits, whether entry loads keep their neighbours intact, whether ports stay independent across the full sweep of ports and entries, and in which exact cycle the done flag rises.

// File: rtl/acl_bridge_pkg.sv
// Package: shared constants for the indirect rule table bridge.
// Assumes byte-wide host data and byte-addressed staging offsets.
package acl_bridge_pkg;
    localparam int          BYTE_W      = 8;
    localparam logic [2:0]  TBL_RULES   = 3'b010;
    localparam logic [1:0]  HA_SEL      = 2'd0;
    localparam logic [1:0]  HA_OFS      = 2'd1;
    localparam logic [1:0]  HA_DAT      = 2'd2;
    localparam logic [7:0]  OFS_MASK_HI = 8'h10;
    localparam logic [7:0]  OFS_MASK_LO = 8'h11;
    localparam logic [7:0]  OFS_ENT_CTL = 8'h12;
    localparam logic [7:0]  OFS_MODE    = 8'h13;
endpackage

// File: rtl/acl_rule_table.sv
// Module: acl_rule_table
// Holds NUM_ENTRIES rule words of WORD_BYTES bytes for one port. A write
// updates only the bytes whose mask bit is set. The read path is
// combinational. Assumes NUM_ENTRIES is a power of two.
module acl_rule_table #(
    parameter int NUM_ENTRIES = 16,
    parameter int WORD_BYTES  = 14,
    localparam int ENT_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ENT_W-1:0]            wr_idx,
    input  logic [WORD_BYTES-1:0]       wr_mask,
    input  logic [WORD_BYTES-1:0][7:0]  wr_word,
    input  logic [ENT_W-1:0]            rd_idx,
    output logic [WORD_BYTES-1:0][7:0]  rd_word
);
    logic [WORD_BYTES-1:0][7:0] mem [NUM_ENTRIES];

    // Storage: clear on reset, byte-masked update on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENTRIES; e++) mem[e] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < WORD_BYTES; b++)
                if (wr_mask[b]) mem[wr_idx][b] <= wr_word[b];
        end
    end

    // Read port: entry selected by rd_idx.
    always_comb rd_word = mem[rd_idx];
endmodule

// File: rtl/acl_port_stage.sv
// Module: acl_port_stage
// Staging area of one port: the rule word, the byte-enable mask, the
// entry-control byte and the mode bit. It also sequences the move to or
// from its table. Assumes 9 <= WORD_BYTES <= 16, NUM_ENTRIES <= 16 and
// XFER_LAT >= 1.
module acl_port_stage
    import acl_bridge_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int WORD_BYTES  = 14,
    parameter int XFER_LAT    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_ofs,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_ofs,
    output logic [7:0] rd_byte
);
    localparam int ENT_W  = $clog2(NUM_ENTRIES);
    localparam int BIDX_W = $clog2(WORD_BYTES);
    localparam int CNT_W  = $clog2(XFER_LAT + 1);
    localparam int HI_W   = WORD_BYTES - 8;

    logic [WORD_BYTES-1:0][7:0] word_q;
    logic [WORD_BYTES-1:0][7:0] tbl_word;
    logic [WORD_BYTES-1:0]      mask_q;
    logic [ENT_W-1:0]           ent_q;
    logic                       dir_q;
    logic                       done_q;
    logic                       mode_q;
    logic [CNT_W-1:0]           cnt_q;
    logic                       move_now;

    assign move_now = (cnt_q == CNT_W'(1));

    acl_rule_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .WORD_BYTES  (WORD_BYTES)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (move_now && dir_q),
        .wr_idx  (ent_q),
        .wr_mask (mask_q),
        .wr_word (word_q),
        .rd_idx  (ent_q),
        .rd_word (tbl_word)
    );

    // Staging registers and move sequencer; a host write overrides the move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mask_q <= '0;
            ent_q  <= '0;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
            mode_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (move_now) begin
                    done_q <= 1'b1;
                    if (!dir_q) word_q <= tbl_word;
                end
            end
            if (wr_en) begin
                if (wr_ofs < 8'(WORD_BYTES)) begin
                    word_q[wr_ofs[BIDX_W-1:0]] <= wr_data;
                end else begin
                    case (wr_ofs)
                        OFS_MASK_HI: mask_q[WORD_BYTES-1:8] <= wr_data[HI_W-1:0];
                        OFS_MASK_LO: mask_q[7:0] <= wr_data;
                        OFS_ENT_CTL: begin
                            ent_q  <= wr_data[ENT_W-1:0];
                            dir_q  <= wr_data[4];
                            done_q <= 1'b0;
                            cnt_q  <= CNT_W'(XFER_LAT);
                        end
                        OFS_MODE:    mode_q <= wr_data[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Read-back mux for the offset the host is looking at.
    always_comb begin
        rd_byte = '0;
        if (rd_ofs < 8'(WORD_BYTES)) begin
            rd_byte = word_q[rd_ofs[BIDX_W-1:0]];
        end else begin
            case (rd_ofs)
                OFS_MASK_HI: rd_byte[HI_W-1:0] = mask_q[WORD_BYTES-1:8];
                OFS_MASK_LO: rd_byte = mask_q[7:0];
                OFS_ENT_CTL: begin
                    rd_byte[ENT_W-1:0] = ent_q;
                    rd_byte[4]         = dir_q;
                    rd_byte[5]         = done_q;
                end
                OFS_MODE:    rd_byte[0] = mode_q;
                default:     rd_byte = '0;
            endcase
        end
    end

    // R8: a control write always leaves the done flag low on the next cycle.
    assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ofs == OFS_ENT_CTL) |=> !done_q);
    // R8: the flag stays low while a move is still pending.
    assert_pending_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> !done_q);
    // R5: unused upper bits of the high mask byte read as zero.
    assert_mask_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ofs == OFS_MASK_HI) |-> (rd_byte[7:HI_W] == '0));
    // R9: reserved bits of the mode byte read as zero.
    assert_mode_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ofs == OFS_MODE) |-> (rd_byte[7:1] == '0));
endmodule

// File: rtl/acl_host_decode.sv
// Module: acl_host_decode
// Host register front end: the select and offset registers, the captured
// data byte and the read-back path. It drives one staging write strobe
// and the offset the ports must present for capture. Assumes
// NUM_PORTS <= 15.
module acl_host_decode
    import acl_bridge_pkg::*;
#(
    parameter int NUM_PORTS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_wr,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    output logic       host_rvalid,
    input  logic [7:0] port_rd_byte,
    output logic       st_wr,
    output logic [3:0] st_idx,
    output logic [7:0] st_ofs,
    output logic [7:0] st_wdata,
    output logic [7:0] rd_ofs
);
    logic [7:0] sel_q;
    logic [7:0] ofs_q;
    logic [7:0] snap_q;
    logic       sel_valid;
    logic       ofs_wr;

    assign sel_valid = (sel_q[7:5] == TBL_RULES) && (sel_q[3:0] >= 4'd1) &&
                       (sel_q[3:0] <= 4'(NUM_PORTS));
    assign ofs_wr    = host_wr && (host_addr == HA_OFS);
    assign st_idx    = sel_q[3:0] - 4'd1;
    assign st_ofs    = ofs_q;
    assign st_wdata  = host_wdata;
    assign st_wr     = host_wr && (host_addr == HA_DAT) && sel_valid && !sel_q[4];
    assign rd_ofs    = ofs_wr ? host_wdata : ofs_q;

    // Select, offset and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            ofs_q  <= '0;
            snap_q <= '0;
        end else begin
            if (host_wr && host_addr == HA_SEL) sel_q <= host_wdata;
            if (ofs_wr) begin
                ofs_q  <= host_wdata;
                snap_q <= (sel_valid && sel_q[4]) ? port_rd_byte : 8'h00;
            end
        end
    end

    // Registered read data with a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) begin
                case (host_addr)
                    HA_SEL:  host_rdata <= sel_q;
                    HA_OFS:  host_rdata <= ofs_q;
                    HA_DAT:  host_rdata <= snap_q;
                    default: host_rdata <= 8'h00;
                endcase
            end
        end
    end

    // R1: read valid follows the strobe by exactly one cycle.
    assert_rvalid_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    assert_rvalid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    // R10: an invalid selection captures zero.
    assert_invalid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_wr && !sel_valid) |=> (snap_q == 8'h00));
endmodule

// File: rtl/acl_indirect_bridge.sv
// Module: acl_indirect_bridge (top)
// Byte-wide indirect access bridge to per-port rule tables. It joins the
// host decoder to one staging/table slice per port. Assumes a synchronous
// host bus whose strobes last one cycle each.
module acl_indirect_bridge
    import acl_bridge_pkg::*;
#(
    parameter int NUM_PORTS   = 5,
    parameter int NUM_ENTRIES = 16,
    parameter int WORD_BYTES  = 14,
    parameter int XFER_LAT    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_wr,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    output logic       host_rvalid
);
    logic                 st_wr;
    logic [3:0]           st_idx;
    logic [7:0]           st_ofs;
    logic [7:0]           st_wdata;
    logic [7:0]           rd_ofs;
    logic [7:0]           sel_byte;
    logic [7:0]           port_rd [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_wr;

    acl_host_decode #(.NUM_PORTS(NUM_PORTS)) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .host_rvalid  (host_rvalid),
        .port_rd_byte (sel_byte),
        .st_wr        (st_wr),
        .st_idx       (st_idx),
        .st_ofs       (st_ofs),
        .st_wdata     (st_wdata),
        .rd_ofs       (rd_ofs)
    );

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            assign port_wr[p] = st_wr && (st_idx == 4'(p));
            acl_port_stage #(
                .NUM_ENTRIES (NUM_ENTRIES),
                .WORD_BYTES  (WORD_BYTES),
                .XFER_LAT    (XFER_LAT)
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (port_wr[p]),
                .wr_ofs  (st_ofs),
                .wr_data (st_wdata),
                .rd_ofs  (rd_ofs),
                .rd_byte (port_rd[p])
            );
        end
    endgenerate

    // Port read-back select by the decoded port index.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NUM_PORTS; i++)
            if (st_idx == 4'(i)) sel_byte = port_rd[i];
    end

    // R11: a staging write reaches at most one port.
    assert_one_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_wr));
endmodule

// File: tb/sim_acl_indirect_bridge.sv
// Bench for acl_indirect_bridge: sweeps every port and entry, checks
// masked commits, the done latency, the padding and invalid selections.
module sim_acl_indirect_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 5;
    localparam int NE  = 16;
    localparam int WB  = 14;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       host_rvalid;

    int n_chk = 0;
    int n_fail = 0;

    acl_indirect_bridge #(.NUM_PORTS(NP), .NUM_ENTRIES(NE), .WORD_BYTES(WB),
                          .XFER_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(int p, int e, int b);
        return 8'((p * 37 + e * 13 + b * 5 + 1) & 255);
    endfunction

    task automatic chk(logic [7:0] got, logic [7:0] exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // All tasks start and end just after a falling edge.
    task automatic hw(logic [1:0] a, logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(logic [1:0] a, output logic [7:0] d);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk({7'b0, host_rvalid}, 8'h01, "R1 rvalid after read strobe");
        d = host_rdata;
    endtask

    task automatic stage_wr(int p, logic [7:0] ofs, logic [7:0] d);
        hw(2'd0, 8'h40 | 8'(p));
        hw(2'd1, ofs);
        hw(2'd2, d);
    endtask

    task automatic stage_rd(int p, logic [7:0] ofs, output logic [7:0] d);
        hw(2'd0, 8'h50 | 8'(p));
        hw(2'd1, ofs);
        hr(2'd2, d);
    endtask

    task automatic move(int p, int e, bit commit);
        logic [7:0] v;
        bit seen = 1'b0;
        stage_wr(p, 8'h12, {3'b0, commit, 4'(e)});
        for (int i = 0; i < 16 && !seen; i++) begin
            stage_rd(p, 8'h12, v);
            seen = v[5];
        end
        chk({7'b0, seen}, 8'h01, "R8 done flag reached");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog got hang exp completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] v, keep;
        logic [13:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk({7'b0, host_rvalid}, 8'h00, "R12 rvalid idle after reset");
        hr(2'd0, v); chk(v, 8'h00, "R12 select reset");
        hr(2'd1, v); chk(v, 8'h00, "R12 offset reset");
        hr(2'd2, v); chk(v, 8'h00, "R12 capture reset");
        hr(2'd3, v); chk(v, 8'h00, "R1 unused address");
        for (int p = 1; p <= NP; p++) begin
            stage_rd(p, 8'h12, v); chk(v, 8'h00, "R12 control reset");
            stage_rd(p, 8'h03, v); chk(v, 8'h00, "R12 staging reset");
        end
        stage_rd(3, 8'h11, v); chk(v, 8'h00, "R12 mask reset");
        v = '1;
        @(negedge clk);
        chk({7'b0, host_rvalid}, 8'h00, "R1 rvalid low without strobe");
        hr(2'd0, v); chk(v, 8'h53, "R1 select readback");
        hr(2'd1, v); chk(v, 8'h11, "R1 offset readback");

        // R8: exact done latency
        for (int n = 0; n <= LAT; n++) begin
            stage_wr(5, 8'h12, 8'h1F);
            repeat (n) @(negedge clk);
            hw(2'd0, 8'h55);
            hw(2'd1, 8'h12);
            hr(2'd2, v);
            chk({7'b0, v[5]}, {7'b0, 1'(n + 2 > LAT)}, "R8 done timing");
            chk(v & 8'h1F, 8'h1F, "R6 control readback");
            repeat (LAT) @(negedge clk);
        end

        // R3 R5 R6 R11: commit distinct words to every port and entry
        for (int p = 1; p <= NP; p++) begin
            stage_wr(p, 8'h10, 8'h3F);
            stage_wr(p, 8'h11, 8'hFF);
            stage_rd(p, 8'h10, v); chk(v, 8'h3F, "R5 mask high readback");
            for (int e = 0; e < NE; e++) begin
                for (int b = 0; b < WB; b++) stage_wr(p, 8'(b), pat(p, e, b));
                if (e == 0) begin
                    stage_rd(p, 8'h0D, v); chk(v, pat(p, 0, 13), "R3 staging byte write");
                end
                move(p, e, 1'b1);
            end
        end
        for (int p = 1; p <= NP; p++)
            for (int e = 0; e < NE; e++) begin
                move(p, e, 1'b0);
                for (int b = 0; b < WB; b++) begin
                    stage_rd(p, 8'(b), v);
                    chk(v, pat(p, e, b), "R6 R11 entry load readback");
                end
            end

        // R7: partial mask on port 2, entry 3
        m = 14'h25A5;
        stage_wr(2, 8'h10, 8'h25);
        stage_wr(2, 8'h11, 8'hA5);
        stage_rd(2, 8'h10, v); chk(v, 8'h25, "R5 mask high partial");
        stage_rd(2, 8'h11, v); chk(v, 8'hA5, "R5 mask low partial");
        for (int b = 0; b < WB; b++) stage_wr(2, 8'(b), ~pat(2, 3, b));
        move(2, 3, 1'b1);
        move(2, 4, 1'b0);
        for (int b = 0; b < WB; b++) begin
            stage_rd(2, 8'(b), v); chk(v, pat(2, 4, b), "R6 neighbour entry intact");
        end
        move(2, 3, 1'b0);
        for (int b = 0; b < WB; b++) begin
            stage_rd(2, 8'(b), v);
            chk(v, m[b] ? ~pat(2, 3, b) : pat(2, 3, b), "R7 masked commit");
        end

        // R9: mode bit, padding, unused offsets
        stage_wr(4, 8'h13, 8'hFF); stage_rd(4, 8'h13, v); chk(v, 8'h01, "R9 mode set");
        stage_wr(4, 8'h13, 8'hFE); stage_rd(4, 8'h13, v); chk(v, 8'h00, "R9 mode clear");
        stage_wr(4, 8'h10, 8'hFF); stage_rd(4, 8'h10, v); chk(v, 8'h3F, "R5 mask high pad");
        stage_wr(4, 8'h0E, 8'h77); stage_rd(4, 8'h0E, v); chk(v, 8'h00, "R9 unused offset");
        stage_rd(4, 8'h1F, v); chk(v, 8'h00, "R9 far offset");

        // R4: a data write in read direction is ignored
        stage_rd(1, 8'h05, keep);
        hw(2'd2, ~keep);
        hw(2'd1, 8'h05);
        hr(2'd2, v); chk(v, keep, "R4 R2 read-direction write ignored");

        // R10: invalid table class and port numbers
        hw(2'd0, 8'h61); hw(2'd1, 8'h05); hw(2'd2, ~keep);
        stage_rd(1, 8'h05, v); chk(v, keep, "R10 wrong table no write");
        hw(2'd0, 8'h71); hw(2'd1, 8'h05); hr(2'd2, v); chk(v, 8'h00, "R10 wrong table reads zero");
        hw(2'd0, 8'h50); hw(2'd1, 8'h05); hr(2'd2, v); chk(v, 8'h00, "R10 port zero reads zero");
        hw(2'd0, 8'h56); hw(2'd1, 8'h05); hr(2'd2, v); chk(v, 8'h00, "R10 port six reads zero");
        hw(2'd0, 8'h46); hw(2'd1, 8'h05); hw(2'd2, 8'hC3);
        hw(2'd0, 8'h40); hw(2'd1, 8'h05); hw(2'd2, 8'hC3);
        for (int p = 1; p <= NP; p++) begin
            stage_rd(p, 8'h05, v);
            chk(v == 8'hC3 ? 8'h01 : 8'h00, 8'h00, "R10 invalid port leaves staging");
        end

        report();
        $finish;
    end
endmodule